// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block takes frames of 16-bit audio samples from a small internal queue and sends them, most significant bit first, on a serial data line. A frame holds between one and eight 16-bit slots. The frame clock is low for the first half of the frame and high for the second half, so with two slots the low half is the left channel. Three framing formats are supported: standard (the first bit is delayed by one bit clock), left-justified and right-justified. The bit clock and the frame clock each have their own polarity inversion. The block can generate both clocks itself or follow clocks that another device supplies.

Each queue entry is one input frame of eight samples. A map register gives each output slot a 4-bit field, and that field chooses which input sample goes into the slot. A global enable, a transmit enable and a per-line enable gate the data lines. When the queue runs dry the block sends zeros and latches an underrun flag.

Top module: `atx_serial_tx`

## Requirements
- R1: `cfg_fmt` selects the framing. Value 0 is standard framing: the MSB of slot 0 is on the second bit after the effective frame clock falls. Value 1 is left-justified: the MSB is on the first bit after that fall. Value 2 is right-justified: the slot is as wide as the sample, so the LSB is the last bit of each slot and the timing equals value 1. Value 3 behaves exactly like value 0.
- R2: The effective frame clock is low for bit positions 0 to (cfg_chan+1)*8-1 of each frame and high for the remaining positions. One frame is (cfg_chan+1)*16 bits long.
- R3: `bclk_out` equals the effective bit clock XOR `cfg_bclk_inv`. Data changes only when the effective bit clock falls and is stable while it rises. With the block idle, the effective bit clock is low.
- R4: `fclk_out` equals the effective frame clock XOR `cfg_fclk_inv`. This inversion does not depend on the bit clock inversion, and every combination of the two is valid.
- R5: With `cfg_follow`=0 the block generates the bit clock, HALF_PERIOD clk cycles per phase, and `clk_drive` is 1 while `glob_en` is 1. With `cfg_follow`=1 the block uses `bclk_in` and `fclk_in` (after inversion), holds `bclk_out`, `fclk_out` and `clk_drive` at 0, and restarts the frame on each fall of the effective frame clock.
- R6: The number of slots is `cfg_chan`+1. Each slot is 16 bits long and is sent MSB first. A value of 1 gives two slots.
- R7: Output slot n takes input sample `cfg_map[4n+3:4n]`. Input sample i is `s_data[16i+15:16i]`. A field value of 8 or more sends zeros in that slot. The identity map is 0x76543210.
- R8: Line i (`sd_out[i]`) carries data only when `glob_en`, `tx_en` and `line_en[i]` are all 1. Otherwise it is 0. The clocks run only when both `glob_en` and `tx_en` are 1.
- R9: If the queue is empty when a frame is due, that frame is sent as zeros and `underrun` goes to 1. The flag stays at 1 until `glob_en` is 0.
- R10: `s_valid`/`s_ready` is a valid/ready handshake. A frame is accepted on a clock edge where both are 1. Up to FIFO_DEPTH frames (4 by default) are held, and `s_ready` is 0 while the queue is full. A frame leaves the queue only when its first bit is due.
- R11: After reset, `s_ready`=1, `sd_out`=0, `underrun`=0 and `clk_drive`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Input frame valid |
| s_ready | output | 1 | Queue can accept a frame |
| s_data | input | 128 | Eight 16-bit samples; sample i at [16i+15:16i] |
| cfg_fmt | input | 2 | Framing: 0 standard, 1 left, 2 right, 3 as 0 |
| cfg_bclk_inv | input | 1 | Invert bit clock at the pins |
| cfg_fclk_inv | input | 1 | Invert frame clock at the pins |
| cfg_follow | input | 1 | 0 generate clocks, 1 follow external clocks |
| cfg_chan | input | 3 | Slot count minus one |
| cfg_map | input | 32 | Per-slot 4-bit input sample index |
| glob_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| line_en | input | 4 | Per-line data output enable |
| bclk_in | input | 1 | External bit clock (follow mode) |
| fclk_in | input | 1 | External frame clock (follow mode) |
| bclk_out | output | 1 | Generated bit clock |
| fclk_out | output | 1 | Generated frame clock |
| clk_drive | output | 1 | Block is driving the clocks |
| sd_out | output | 4 | Serial data lines |
| underrun | output | 1 | Sticky queue-empty flag |

## Verification
When the block generates the clocks, the data bit and the falling bit-clock pin change on the same clk edge. The bench therefore reads `sd_out` and `fclk_out` at the clk falling edge after it sees the effective bit clock rise, and bit n is compared with the value computed for frame position n. When the block follows external clocks, the two-flop synchronizer plus the output register put the data update about three clk cycles after the driven fall. The bench waits six cycles before it samples, then drives the rise. Queue acceptance is counted at the edge that follows a sampled `s_ready`=1. The underrun flag is read a few bits after the frame load it belongs to.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int SAMPLE_W = 16;
  localparam int MAP_W    = 4;

  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;
endpackage

// File: rtl/atx_sample_fifo.sv
module atx_sample_fifo #(
  parameter int W     = 128,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [W-1:0]               in_data,
  output logic                       head_valid,
  output logic [W-1:0]               head_data,
  input  logic                       pop,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push;

  assign in_ready   = (count != CW'(DEPTH));
  assign push       = in_valid && in_ready;
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];
  assign level      = count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/atx_clk_unit.sv
module atx_clk_unit #(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic follow,
  input  logic bclk_inv,
  input  logic fclk_inv,
  input  logic bclk_in,
  input  logic fclk_in,
  output logic bit_fall,
  output logic ext_fclk_eff,
  output logic bclk_pin
);
  localparam int HW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

  logic [HW-1:0] hcnt;
  logic          gen_b;
  logic [2:0]    bsync;
  logic [1:0]    fsync;
  logic          toggle, ext_now, ext_prev;

  assign toggle   = run && !follow && (hcnt == HW'(HALF_PERIOD-1));
  assign ext_now  = bsync[1] ^ bclk_inv;
  assign ext_prev = bsync[2] ^ bclk_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      gen_b <= 1'b0;
      bsync <= '0;
      fsync <= '0;
    end else begin
      bsync <= {bsync[1:0], bclk_in};
      fsync <= {fsync[0], fclk_in};
      if (!run || follow) begin
        hcnt  <= '0;
        gen_b <= 1'b0;
      end else if (toggle) begin
        hcnt  <= '0;
        gen_b <= !gen_b;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // a fall of the effective bit clock, from the divider or the synchronizer
  assign bit_fall     = follow ? (run && ext_prev && !ext_now) : (toggle && gen_b);
  assign ext_fclk_eff = fsync[1] ^ fclk_inv;
  assign bclk_pin     = follow ? 1'b0 : (gen_b ^ bclk_inv);
endmodule

// File: rtl/atx_serializer.sv
module atx_serializer
  import atx_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  localparam int CH_W     = $clog2(MAX_SLOTS),
  localparam int POS_W    = CH_W + 4,
  localparam int FRAME_W  = MAX_SLOTS * SAMPLE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     glob_en,
  input  logic                     bit_fall,
  input  logic                     follow,
  input  logic                     ext_fclk_eff,
  input  logic [1:0]               fmt,
  input  logic [CH_W-1:0]          chan,
  input  logic [MAP_W*MAX_SLOTS-1:0] map,
  input  logic                     head_valid,
  input  logic [FRAME_W-1:0]       head_data,
  output logic                     pop,
  output logic                     sd,
  output logic                     fclk_eff,
  output logic                     underrun,
  output logic [POS_W-1:0]         pos
);
  fmt_e               fm;
  logic               std, wrap, resync, load, nbit, prev_fs;
  logic [POS_W-1:0]   last, half, npos, d, bidx;
  logic [FRAME_W-1:0] cur, frame_new;

  assign fm   = fmt_e'(fmt);
  assign std  = (fm == FMT_STD) || (fm == FMT_RSVD);
  assign last = {chan, 4'hF};
  assign half = POS_W'({1'b0, chan} + 1'b1) << 3;

  // slot placement through the per-slot sample index map
  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    logic [MAP_W-1:0] sel;
    logic [CH_W-1:0]  sel_lo;
    assign sel    = map[MAP_W*s +: MAP_W];
    assign sel_lo = sel[CH_W-1:0];
    assign frame_new[SAMPLE_W*s +: SAMPLE_W] =
      (head_valid && ({1'b0, sel} < (MAP_W+1)'(MAX_SLOTS))) ?
      head_data[{sel_lo, 4'b0000} +: SAMPLE_W] : '0;
  end

  always_comb begin
    wrap   = (pos == last);
    resync = follow && !ext_fclk_eff && prev_fs;
    npos   = (wrap || resync) ? '0 : pos + 1'b1;
    if (std) d = (npos == '0) ? last : npos - 1'b1;
    else     d = npos;
    load = (d == '0);
    bidx = {d[POS_W-1:4], ~d[3:0]};
    nbit = load ? frame_new[bidx] : cur[bidx];
  end

  assign pop = run && bit_fall && load && head_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      sd       <= 1'b0;
      fclk_eff <= 1'b1;
      cur      <= '0;
      underrun <= 1'b0;
      prev_fs  <= 1'b0;
    end else begin
      if (!glob_en) underrun <= 1'b0;
      if (!run) begin
        pos      <= last;
        sd       <= 1'b0;
        fclk_eff <= 1'b1;
        cur      <= '0;
        prev_fs  <= 1'b0;
      end else if (bit_fall) begin
        pos      <= npos;
        sd       <= nbit;
        fclk_eff <= (npos >= half);
        prev_fs  <= ext_fclk_eff;
        if (load) begin
          cur <= frame_new;
          if (!head_valid) underrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/atx_serial_tx.sv
module atx_serial_tx
  import atx_pkg::*;
#(
  parameter int MAX_SLOTS   = 8,
  parameter int LINES       = 4,
  parameter int FIFO_DEPTH  = 4,
  parameter int HALF_PERIOD = 2,
  localparam int CH_W       = $clog2(MAX_SLOTS),
  localparam int POS_W      = CH_W + 4,
  localparam int FRAME_W    = MAX_SLOTS * SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [FRAME_W-1:0]         s_data,
  input  logic [1:0]                 cfg_fmt,
  input  logic                       cfg_bclk_inv,
  input  logic                       cfg_fclk_inv,
  input  logic                       cfg_follow,
  input  logic [CH_W-1:0]            cfg_chan,
  input  logic [MAP_W*MAX_SLOTS-1:0] cfg_map,
  input  logic                       glob_en,
  input  logic                       tx_en,
  input  logic [LINES-1:0]           line_en,
  input  logic                       bclk_in,
  input  logic                       fclk_in,
  output logic                       bclk_out,
  output logic                       fclk_out,
  output logic                       clk_drive,
  output logic [LINES-1:0]           sd_out,
  output logic                       underrun
);
  logic                            run, bit_fall, ext_fclk_eff, pop, head_valid;
  logic                            sd_core, fclk_core;
  logic [FRAME_W-1:0]              head_data;
  logic [POS_W-1:0]                pos_core;
  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level;

  assign run = glob_en && tx_en;

  atx_sample_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_ready),
    .in_data(s_data), .head_valid(head_valid), .head_data(head_data),
    .pop(pop), .level(fifo_level)
  );

  atx_clk_unit #(.HALF_PERIOD(HALF_PERIOD)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .follow(cfg_follow),
    .bclk_inv(cfg_bclk_inv), .fclk_inv(cfg_fclk_inv),
    .bclk_in(bclk_in), .fclk_in(fclk_in), .bit_fall(bit_fall),
    .ext_fclk_eff(ext_fclk_eff), .bclk_pin(bclk_out)
  );

  atx_serializer #(.MAX_SLOTS(MAX_SLOTS)) u_ser (
    .clk(clk), .rst_n(rst_n), .run(run), .glob_en(glob_en),
    .bit_fall(bit_fall), .follow(cfg_follow), .ext_fclk_eff(ext_fclk_eff),
    .fmt(cfg_fmt), .chan(cfg_chan), .map(cfg_map),
    .head_valid(head_valid), .head_data(head_data), .pop(pop),
    .sd(sd_core), .fclk_eff(fclk_core), .underrun(underrun), .pos(pos_core)
  );

  assign fclk_out  = cfg_follow ? 1'b0 : (fclk_core ^ cfg_fclk_inv);
  assign clk_drive = glob_en && !cfg_follow;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign sd_out[i] = sd_core && run && line_en[i];
  end
endmodule

// File: rtl/atx_serial_tx_chk.sv
module atx_serial_tx_chk #(
  parameter int MAX_SLOTS  = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = $clog2(MAX_SLOTS),
  localparam int POS_W     = CH_W + 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            run,
  input logic                            glob_en,
  input logic                            bit_fall,
  input logic                            sd_core,
  input logic                            fclk_core,
  input logic [POS_W-1:0]                pos_core,
  input logic [CH_W-1:0]                 cfg_chan,
  input logic                            underrun,
  input logic                            pop,
  input logic                            head_valid,
  input logic                            s_ready,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level
);
  logic [POS_W-1:0] frame_last, frame_half;
  assign frame_last = POS_W'(({1'b0, cfg_chan} + 1'b1) * 16 - 1);
  assign frame_half = POS_W'(({1'b0, cfg_chan} + 1'b1) * 8);

  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !pop) |=> !s_ready);

  p_pop_has_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && glob_en) |=> underrun);

  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(sd_core)) |-> $past(bit_fall));

  p_frame_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(cfg_chan) && $rose(fclk_core)) |-> (pos_core == frame_half));

  p_pos_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(cfg_chan)) |-> (pos_core <= frame_last));
endmodule

bind atx_serial_tx atx_serial_tx_chk #(.MAX_SLOTS(MAX_SLOTS), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .glob_en(glob_en), .bit_fall(bit_fall),
  .sd_core(sd_core), .fclk_core(fclk_core), .pos_core(pos_core),
  .cfg_chan(cfg_chan), .underrun(underrun), .pop(pop),
  .head_valid(head_valid), .s_ready(s_ready), .fifo_level(fifo_level)
);

// File: tb/atx_serial_tx_test.sv
module atx_serial_tx_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [127:0] s_data = '0;
  logic [1:0]   cfg_fmt = 2'd0;
  logic         cfg_bclk_inv = 1'b0, cfg_fclk_inv = 1'b0, cfg_follow = 1'b0;
  logic [2:0]   cfg_chan = 3'd1;
  logic [31:0]  cfg_map = 32'h76543210;
  logic         glob_en = 1'b0, tx_en = 1'b0;
  logic [3:0]   line_en = 4'b0001;
  logic         bclk_in = 1'b0, fclk_in = 1'b0;
  logic         bclk_out, fclk_out, clk_drive, underrun;
  logic [3:0]   sd_out;

  int checks = 0, errors = 0, cfg_id = 0, cyc = 0;

  atx_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cfg_fmt(cfg_fmt), .cfg_bclk_inv(cfg_bclk_inv), .cfg_fclk_inv(cfg_fclk_inv),
    .cfg_follow(cfg_follow), .cfg_chan(cfg_chan), .cfg_map(cfg_map),
    .glob_en(glob_en), .tx_en(tx_en), .line_en(line_en),
    .bclk_in(bclk_in), .fclk_in(fclk_in), .bclk_out(bclk_out), .fclk_out(fclk_out),
    .clk_drive(clk_drive), .sd_out(sd_out), .underrun(underrun)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cfg=%0d act=%0d exp=%0d", tag, cfg_id, act, exp);
    end
  endtask

  function automatic logic [15:0] smp(int f, int i);
    return 16'((cfg_id * 733 + f * 2741 + i * 97 + 4951) ^ (i << 9));
  endfunction

  function automatic logic [127:0] mkframe(int f);
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[16*i +: 16] = smp(f, i);
    return v;
  endfunction

  // expected bit for stream index m (negative means before any frame)
  function automatic logic exp_bit(int m, int fb, logic [31:0] mp, int nfr);
    int f, d, s, k, idx;
    logic [15:0] w;
    if (m < 0) return 1'b0;
    f = m / fb; d = m % fb; s = d / 16; k = d % 16;
    idx = int'(mp[4*s +: 4]);
    if (f >= nfr || idx >= 8) w = '0;
    else w = smp(f, idx);
    return w[15-k];
  endfunction

  task automatic push_frames(int nfr);
    for (int f = 0; f < nfr; f++) begin
      s_valid = 1'b1;
      s_data  = mkframe(f);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic run_master(int fmt, bit bi, bit fi, int ch, logic [31:0] mp, int nfr, bit do_push);
    int fb = (ch + 1) * 16;
    int nbits = (nfr + 1) * fb + 2;
    int n = 0, bad = 0, badf = 0, badl = 0, guard = 0, m;
    int fa = 0, fe_v = 0;
    bit seen = 0, prevb, effb, stdf, e, ef;
    stdf = (fmt == 0 || fmt == 3);
    glob_en = 1'b0; tx_en = 1'b0;
    cfg_fmt = 2'(fmt); cfg_bclk_inv = bi; cfg_fclk_inv = fi; cfg_follow = 1'b0;
    cfg_chan = 3'(ch); cfg_map = mp;
    repeat (3) @(negedge clk);
    if (do_push) push_frames(nfr);
    @(negedge clk);
    check(bclk_out == bi, "R3 idle bit clock level", int'(bclk_out), int'(bi));
    glob_en = 1'b1; tx_en = 1'b1; line_en = 4'b0101;
    prevb = bclk_out ^ bi;
    while (n < nbits && guard < 20000) begin
      @(negedge clk);
      guard++;
      effb = bclk_out ^ bi;
      if (prevb && !effb) seen = 1;
      else if (!prevb && effb && seen) begin
        m = stdf ? n - 1 : n;
        e = exp_bit(m, fb, mp, nfr);
        if (sd_out[0] !== e) begin
          if (bad == 0) begin fa = int'(sd_out[0]); fe_v = int'(e); end
          bad++;
        end
        ef = ((n % fb) >= fb / 2);
        if ((fclk_out ^ fi) !== ef) badf++;
        if (sd_out[2] !== sd_out[0] || sd_out[1] !== 1'b0 || sd_out[3] !== 1'b0) badl++;
        if (n == fb + 2 && nfr >= 2)
          check(underrun == 1'b0, "R9 no underrun while queue holds frames", int'(underrun), 0);
        n++;
      end
      prevb = effb;
    end
    check(bad == 0, "R1 R6 R7 serial stream bits", fa, fe_v);
    check(badf == 0, "R2 R4 frame clock level per bit", badf, 0);
    check(badl == 0, "R8 per-line gating", badl, 0);
    check(clk_drive == 1'b1, "R5 clock drive in generate mode", int'(clk_drive), 1);
    check(underrun == 1'b1, "R9 underrun after queue empties", int'(underrun), 1);
    glob_en = 1'b0; tx_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(underrun == 1'b0, "R9 underrun cleared by global disable", int'(underrun), 0);
  endtask

  task automatic run_slave(int fmt, bit bi, bit fi);
    int fb = 32, nfr = 2;
    int nbits = (nfr + 1) * fb + 2;
    int bad = 0, m, fa = 0, fe_v = 0, pin_bad = 0;
    bit stdf, e;
    stdf = (fmt == 0 || fmt == 3);
    glob_en = 1'b0; tx_en = 1'b0;
    cfg_fmt = 2'(fmt); cfg_bclk_inv = bi; cfg_fclk_inv = fi; cfg_follow = 1'b1;
    cfg_chan = 3'd1; cfg_map = 32'h76543210; line_en = 4'b1111;
    bclk_in = 1'b1 ^ bi; fclk_in = 1'b1 ^ fi;
    repeat (4) @(negedge clk);
    push_frames(nfr);
    glob_en = 1'b1; tx_en = 1'b1;
    repeat (6) @(negedge clk);
    for (int n = 0; n < nbits; n++) begin
      fclk_in = (((n % fb) >= fb / 2) ? 1'b1 : 1'b0) ^ fi;
      bclk_in = 1'b0 ^ bi;
      repeat (6) @(negedge clk);
      m = stdf ? n - 1 : n;
      e = exp_bit(m, fb, 32'h76543210, nfr);
      if (sd_out[0] !== e || sd_out[3] !== e) begin
        if (bad == 0) begin fa = int'(sd_out[0]); fe_v = int'(e); end
        bad++;
      end
      if (bclk_out !== 1'b0 || fclk_out !== 1'b0 || clk_drive !== 1'b0) pin_bad++;
      bclk_in = 1'b1 ^ bi;
      repeat (6) @(negedge clk);
    end
    check(bad == 0, "R5 R1 follow-mode stream bits", fa, fe_v);
    check(pin_bad == 0, "R5 clock outputs quiet in follow mode", pin_bad, 0);
    check(underrun == 1'b1, "R9 underrun in follow mode", int'(underrun), 1);
    glob_en = 1'b0; tx_en = 1'b0; cfg_follow = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  logic [31:0] maps [3];

  initial begin
    int acc, idle_bad;
    bit rdy;
    maps[0] = 32'h76543210; maps[1] = 32'h67452301; maps[2] = 32'h000000F2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(s_ready == 1'b1, "R11 ready after reset", int'(s_ready), 1);
    check(sd_out == 4'b0, "R11 data lines low after reset", int'(sd_out), 0);
    check(underrun == 1'b0, "R11 underrun clear after reset", int'(underrun), 0);
    check(clk_drive == 1'b0, "R11 clocks not driven after reset", int'(clk_drive), 0);

    // R10 back-pressure with transmit held off, R8 nothing moves
    cfg_id = 500;
    cfg_fmt = 2'd1; cfg_chan = 3'd1; cfg_map = 32'h76543210;
    glob_en = 1'b1; tx_en = 1'b0; line_en = 4'b1111;
    acc = 0; idle_bad = 0;
    for (int t = 0; t < 8; t++) begin
      s_valid = 1'b1;
      s_data  = mkframe(acc);
      rdy = s_ready;
      @(negedge clk);
      if (rdy) acc++;
      if (sd_out !== 4'b0 || bclk_out !== 1'b0) idle_bad++;
    end
    s_valid = 1'b0;
    check(acc == 4, "R10 frames accepted before queue full", acc, 4);
    check(s_ready == 1'b0, "R10 ready low when full", int'(s_ready), 0);
    check(idle_bad == 0, "R8 no data or clock with transmit disabled", idle_bad, 0);
    run_master(1, 1'b0, 1'b0, 1, 32'h76543210, 4, 1'b0);
    check(s_ready == 1'b1, "R10 queue drained by transmission", int'(s_ready), 1);

    // sweep of format, both inversions, slot count and slot map (R1..R9)
    for (int mi = 0; mi < 3; mi++)
      for (int ci = 0; ci < 2; ci++)
        for (int fmt = 0; fmt < 4; fmt++)
          for (int inv = 0; inv < 4; inv++) begin
            cfg_id = mi * 32 + ci * 16 + fmt * 4 + inv;
            run_master(fmt, inv[0], inv[1], ci ? 3 : 1, maps[mi], 3, 1'b1);
          end

    // follow-mode sweep over formats and inversions (R5)
    for (int fmt = 0; fmt < 4; fmt++) begin
      cfg_id = 600 + fmt;
      run_slave(fmt, fmt[0], fmt[1]);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule